// File: doc/BRIEF.md
# Serial Inversionless Error-Locator Solver

This block finds the error locator polynomial of a Reed–Solomon code that corrects up to T symbol errors, given the 2T syndromes of a received word. It runs the inversionless form of the Berlekamp–Massey recursion. Each step updates one locator coefficient per clock, so only three GF(2^m) multipliers are needed and the design has no field inverter. The longest path is one multiplier followed by an XOR.

A decoder presents the syndrome vector and pulses `start_i`. The block latches all syndromes on that edge and runs 2T steps of T+2 cycles each. It then raises `done_o` for one cycle. The locator coefficients and their degree stay on the outputs until the next accepted start. The locator is correct up to a nonzero scale factor, which a root search does not care about.

Top module: `bm_serial_solver`

## Requirements
- R1: After reset, `done_o` is 0, coefficient 0 of `loc_o` is 1, all other coefficients are 0, and `deg_o` is 0.
- R2: The syndromes are sampled on the clock edge that accepts `start_i`. Changing `syn_i` after that edge has no effect on the result.
- R3: Arithmetic is in GF(2^8) with primitive polynomial x^8+x^4+x^3+x^2+1. Syndrome S_j sits in `syn_i[8(j-1)+7:8(j-1)]` and locator coefficient i sits in `loc_o[8i+7:8i]`. For a single error at location α^p, coefficient 1 equals coefficient 0 times α^p.
- R4: The result equals, coefficient for coefficient, 2T steps of the inversionless recursion. That recursion starts from locator 1, auxiliary polynomial 1, previous discrepancy 1 and degree variable 0. Each new coefficient i is prev·λ_i + δ·b_(i-1). On a nonzero δ with a non-negative degree variable k, the recursion swaps: b takes the old locator, the previous discrepancy takes δ, and k becomes −k−1. Otherwise b shifts up one place and k increments.
- R5: For any error pattern of weight w ≤ T, `deg_o` equals w and the locator evaluates to zero at α^(−p) for every error position p.
- R6: `done_o` rises exactly 2T·(T+2) = 160 cycles after the edge that accepted `start_i` and stays high for exactly one cycle.
- R7: A `start_i` pulse while a run is in progress is ignored. The timing and the result of that run are unchanged.
- R8: Between `done_o` and the next accepted start, `loc_o` and `deg_o` hold their values.
- R9: All-zero syndromes give locator 1 and degree 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe; sampled only when idle |
| syn_i | input | 128 | Syndromes S1..S16, S1 in the low byte |
| loc_o | output | 72 | Locator coefficients 0..8, coefficient 0 in the low byte |
| deg_o | output | 4 | Index of the highest nonzero locator coefficient |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
The hardest behaviour to reach from the ports is the interplay of the two update branches. A step with a zero discrepancy, or a nonzero discrepancy arriving while the degree variable is negative, must shift the auxiliary polynomial instead of swapping it. Low-weight patterns drive these branches: once the locator is complete, every later discrepancy is zero. Each weight from 0 to T is run with random positions and values, and every run is compared exactly against a behavioural model of the recursion. Some runs also change the syndromes right after start or pulse start in the middle of the run.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} bm_state_e;
endpackage

// File: rtl/bm_gf_mul.sv
module bm_gf_mul #(
  parameter int          M   = 8,
  parameter logic [M-1:0] RED = 8'h1D
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] p_o
);
  logic [M-1:0] sh;
  logic [M-1:0] sum;

  always_comb begin
    sum = '0;
    sh  = a_i;
    for (int i = 0; i < M; i++) begin
      if (b_i[i]) sum = sum ^ sh;
      sh = {sh[M-2:0], 1'b0} ^ (sh[M-1] ? RED : '0);
    end
  end

  assign p_o = sum;
endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
#(
  parameter int T  = 8,
  parameter int CW = $clog2(T + 2),
  parameter int SW = $clog2(2 * T)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          init_o,
  output logic          run_o,
  output logic [CW-1:0] cyc_o,
  output logic [SW-1:0] step_o,
  output logic          done_o
);
  localparam int NS = 2 * T;

  bm_state_e     st_q, st_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic [SW-1:0] step_q, step_d;
  logic          done_q, done_d;
  logic          end_step, fin;

  assign end_step = (st_q == ST_RUN) && (cyc_q == CW'(T + 1));
  assign fin      = end_step && (step_q == SW'(NS - 1));

  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    step_d = step_q;
    done_d = fin;
    if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_d   = ST_RUN;
        cyc_d  = '0;
        step_d = '0;
      end
    end else if (end_step) begin
      cyc_d = '0;
      if (fin) st_d = ST_IDLE;
      else     step_d = step_q + SW'(1);
    end else begin
      cyc_d = cyc_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cyc_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cyc_q  <= cyc_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign init_o = (st_q == ST_IDLE) && start_i;
  assign run_o  = (st_q == ST_RUN);
  assign cyc_o  = cyc_q;
  assign step_o = step_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && start_i && !fin) |=> (st_q == ST_RUN)); // R7
  AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= CW'(T + 1)); // R6
endmodule

// File: rtl/bm_datapath.sv
module bm_datapath #(
  parameter int           M   = 8,
  parameter int           T   = 8,
  parameter logic [M-1:0] RED = 8'h1D,
  parameter int           CW  = $clog2(T + 2),
  parameter int           SW  = $clog2(2 * T)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_i,
  input  logic                 run_i,
  input  logic [CW-1:0]        cyc_i,
  input  logic [SW-1:0]        step_i,
  input  logic [2*T*M-1:0]     syn_i,
  output logic [(T+1)*M-1:0]   loc_o
);
  localparam int NC = T + 1;
  localparam int NS = 2 * T;
  localparam int KW = $clog2(2 * T + 1) + 2;
  localparam int NMUL = 3;

  logic [M-1:0]          lam_q [NC];
  logic [M-1:0]          lam_d [NC];
  logic [M-1:0]          bb_q  [NC];
  logic [M-1:0]          bb_d  [NC];
  logic [M-1:0]          syn_q [NS];
  logic [M-1:0]          syn_d [NS];
  logic [M-1:0]          gam_q, gam_d;
  logic [M-1:0]          dlt_q, dlt_d;
  logic [M-1:0]          acc_q, acc_d;
  logic [M-1:0]          hold_q, hold_d;
  logic signed [KW-1:0]  k_q, k_d;

  logic [M-1:0] cur_lam, cur_bb, prv_lam, s_val, bb_low, new_coef;
  logic         upd, acc_on, last, swap;
  int           sidx;

  logic [M-1:0] ma [NMUL];
  logic [M-1:0] mb [NMUL];
  logic [M-1:0] mp [NMUL];

  // operand selection: current coefficient, previous coefficient, syndrome
  always_comb begin
    cur_lam = '0;
    cur_bb  = '0;
    prv_lam = '0;
    for (int q = 0; q < NC; q++) begin
      if (cyc_i == CW'(q)) begin
        cur_lam = lam_q[q];
        cur_bb  = bb_q[q];
      end
      if (cyc_i == CW'(q + 1)) prv_lam = lam_q[q];
    end
    sidx  = int'(step_i) + 3 - int'(cyc_i);
    s_val = '0;
    for (int q = 0; q < NS; q++)
      if (sidx == q + 1) s_val = syn_q[q];
  end

  assign upd    = run_i && (cyc_i <= CW'(T));
  assign acc_on = run_i && (cyc_i != '0);
  assign last   = run_i && (cyc_i == CW'(T + 1));
  assign swap   = (dlt_q != '0) && !k_q[KW-1];
  assign bb_low = (cyc_i == '0) ? '0 : hold_q;

  assign ma[0] = gam_q;   assign mb[0] = cur_lam;
  assign ma[1] = dlt_q;   assign mb[1] = bb_low;
  assign ma[2] = prv_lam; assign mb[2] = s_val;

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    bm_gf_mul #(.M(M), .RED(RED)) u_mul (
      .a_i (ma[g]),
      .b_i (mb[g]),
      .p_o (mp[g])
    );
  end

  assign new_coef = mp[0] ^ mp[1];

  always_comb begin
    lam_d  = lam_q;
    bb_d   = bb_q;
    syn_d  = syn_q;
    gam_d  = gam_q;
    dlt_d  = dlt_q;
    acc_d  = acc_q;
    hold_d = hold_q;
    k_d    = k_q;
    if (init_i) begin
      for (int q = 0; q < NC; q++) begin
        lam_d[q] = (q == 0) ? M'(1) : '0;
        bb_d[q]  = (q == 0) ? M'(1) : '0;
      end
      for (int q = 0; q < NS; q++) syn_d[q] = syn_i[q*M +: M];
      gam_d  = M'(1);
      dlt_d  = syn_i[M-1:0];
      acc_d  = '0;
      hold_d = '0;
      k_d    = '0;
    end else begin
      if (upd) begin
        for (int q = 0; q < NC; q++) begin
          if (cyc_i == CW'(q)) begin
            lam_d[q] = new_coef;
            bb_d[q]  = swap ? cur_lam : bb_low;
          end
        end
        hold_d = cur_bb;
      end
      if (acc_on) acc_d = (cyc_i == CW'(1)) ? mp[2] : (acc_q ^ mp[2]);
      if (last) begin
        dlt_d = acc_q ^ mp[2];
        if (swap) begin
          gam_d = dlt_q;
          k_d   = ~k_q;
        end else begin
          k_d   = k_q + KW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NC; q++) begin
        lam_q[q] <= (q == 0) ? M'(1) : '0;
        bb_q[q]  <= (q == 0) ? M'(1) : '0;
      end
      for (int q = 0; q < NS; q++) syn_q[q] <= '0;
      gam_q  <= M'(1);
      dlt_q  <= '0;
      acc_q  <= '0;
      hold_q <= '0;
      k_q    <= '0;
    end else begin
      lam_q  <= lam_d;
      bb_q   <= bb_d;
      syn_q  <= syn_d;
      gam_q  <= gam_d;
      dlt_q  <= dlt_d;
      acc_q  <= acc_d;
      hold_q <= hold_d;
      k_q    <= k_d;
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_out
    assign loc_o[g*M +: M] = lam_q[g];
  end

  AST_GAM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (gam_q != '0)); // R4
  AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !init_i) |=> $stable(loc_o)); // R8
  AST_SYN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (dlt_q == $past(syn_i[M-1:0]))); // R2
endmodule

// File: rtl/bm_degree.sv
module bm_degree #(
  parameter int M  = 8,
  parameter int T  = 8,
  parameter int DW = $clog2(T + 1)
) (
  input  logic [T*M-1:0] hi_coef_i,
  output logic [DW-1:0]  deg_o
);
  always_comb begin
    deg_o = '0;
    for (int q = 0; q < T; q++)
      if (hi_coef_i[q*M +: M] != '0) deg_o = DW'(q + 1);
  end
endmodule

// File: rtl/bm_serial_solver.sv
module bm_serial_solver #(
  parameter int         M    = 8,
  parameter int         T    = 8,
  parameter logic [M:0] POLY = 9'h11D,
  parameter int         DW   = $clog2(T + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [2*T*M-1:0]     syn_i,
  output logic [(T+1)*M-1:0]   loc_o,
  output logic [DW-1:0]        deg_o,
  output logic                 done_o
);
  localparam int           CW  = $clog2(T + 2);
  localparam int           SW  = $clog2(2 * T);
  localparam logic [M-1:0] RED = POLY[M-1:0];

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          init, run;
  logic [CW-1:0] cyc;
  logic [SW-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bm_ctrl #(.T(T), .CW(CW), .SW(SW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .init_o  (init),
    .run_o   (run),
    .cyc_o   (cyc),
    .step_o  (step),
    .done_o  (done_o)
  );

  bm_datapath #(.M(M), .T(T), .RED(RED), .CW(CW), .SW(SW)) u_dp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .init_i (init),
    .run_i  (run),
    .cyc_i  (cyc),
    .step_i (step),
    .syn_i  (syn_i),
    .loc_o  (loc_o)
  );

  bm_degree #(.M(M), .T(T), .DW(DW)) u_deg (
    .hi_coef_i (loc_o[(T+1)*M-1:M]),
    .deg_o     (deg_o)
  );
endmodule

// File: tb/bm_serial_solver_tb.sv
module bm_serial_solver_tb;
  localparam int M = 8;
  localparam int T = 8;
  localparam int NS = 2 * T;
  localparam int LAT = NS * (T + 2);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [NS*M-1:0]  syn = '0;
  logic [(T+1)*M-1:0] loc;
  logic [3:0]       deg;
  logic             done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int exp_t [0:254];
  int log_t [0:255];
  int mlam [0:T];
  int s_arr [1:NS];
  int pos [0:T-1];

  always #10 clk = ~clk;

  bm_serial_solver u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .syn_i(syn),
    .loc_o(loc), .deg_o(deg), .done_o(done)
  );

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 255];
  endfunction

  function automatic int coef(int i);
    return int'(loc[i*M +: M]);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model();
    int b [0:T];
    int nl [0:T];
    int gam, k, dl;
    for (int i = 0; i <= T; i++) begin mlam[i] = (i == 0); b[i] = (i == 0); end
    gam = 1; k = 0;
    for (int r = 0; r < NS; r++) begin
      dl = 0;
      for (int i = 0; i <= T; i++)
        if (r + 1 - i >= 1) dl ^= gmul(mlam[i], s_arr[r + 1 - i]);
      for (int i = 0; i <= T; i++)
        nl[i] = gmul(gam, mlam[i]) ^ ((i > 0) ? gmul(dl, b[i-1]) : 0);
      if (dl != 0 && k >= 0) begin
        for (int i = 0; i <= T; i++) b[i] = mlam[i];
        gam = dl; k = -k - 1;
      end else begin
        for (int i = T; i > 0; i--) b[i] = b[i-1];
        b[0] = 0; k = k + 1;
      end
      for (int i = 0; i <= T; i++) mlam[i] = nl[i];
    end
  endtask

  task automatic run_case(int w, bit poke);
    int val;
    bit dup;
    logic [(T+1)*M-1:0] snap;
    for (int e = 0; e < w; e++) begin
      do begin
        pos[e] = $urandom % 255;
        dup = 0;
        for (int f = 0; f < e; f++) if (pos[f] == pos[e]) dup = 1;
      end while (dup);
    end
    for (int j = 1; j <= NS; j++) s_arr[j] = 0;
    for (int e = 0; e < w; e++) begin
      val = 1 + ($urandom % 255);
      for (int j = 1; j <= NS; j++)
        s_arr[j] ^= gmul(val, exp_t[(j * pos[e]) % 255]);
    end
    model();
    @(negedge clk);
    for (int j = 1; j <= NS; j++) syn[(j-1)*M +: M] = M'(s_arr[j]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    syn = ~syn;  // altered after the accepting edge: must not matter (R2)
    for (int cnt = 1; cnt <= LAT + 10; cnt++) begin
      @(negedge clk);
      if (poke && cnt == 50) start = 1'b1;
      if (poke && cnt == 51) start = 1'b0;
      if (poke) check(done == (cnt == LAT), "R7 done timing with start mid-run", int'(done), int'(cnt == LAT));
      else      check(done == (cnt == LAT), "R6 done pulse timing", int'(done), int'(cnt == LAT));
      if (cnt == LAT) begin
        snap = loc;
        for (int i = 0; i <= T; i++)
          check(coef(i) == mlam[i], "R4 coefficient vs model (syndromes altered after start, R2)", coef(i), mlam[i]);
        check(int'(deg) == w, "R5 degree equals weight", int'(deg), w);
        for (int e = 0; e < w; e++) begin
          int x, xp, ev;
          x = exp_t[(255 - pos[e]) % 255]; xp = 1; ev = 0;
          for (int i = 0; i <= T; i++) begin ev ^= gmul(coef(i), xp); xp = gmul(xp, x); end
          check(ev == 0, "R5 locator root at error position", ev, 0);
        end
        if (w == 1)
          check(coef(1) == gmul(coef(0), exp_t[pos[0]]), "R3 single error coefficient ratio",
                coef(1), gmul(coef(0), exp_t[pos[0]]));
        if (w == 0) begin
          check(coef(0) == 1, "R9 zero syndromes coefficient 0", coef(0), 1);
          check(loc[(T+1)*M-1:M] == '0, "R9 zero syndromes upper coefficients", int'(loc[(T+1)*M-1:M] != '0), 0);
        end
      end
    end
    check(loc == snap, "R8 locator held after done", int'(loc != snap), 0);
    check(int'(deg) == w, "R8 degree held after done", int'(deg), w);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    exp_t[0] = 1;
    for (int i = 1; i < 255; i++) begin
      exp_t[i] = exp_t[i-1] << 1;
      if (exp_t[i] > 255) exp_t[i] ^= 'h11D;
    end
    log_t[0] = 0;
    for (int i = 0; i < 255; i++) log_t[exp_t[i]] = i;
  end

  initial begin
    void'($urandom(17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(coef(0) == 1, "R1 coefficient 0 after reset", coef(0), 1);
    check(loc[(T+1)*M-1:M] == '0, "R1 upper coefficients after reset", int'(loc[(T+1)*M-1:M] != '0), 0);
    check(deg == 4'd0, "R1 degree after reset", int'(deg), 0);
    run_case(0, 0);
    run_case(0, 1);
    for (int w = 1; w <= T; w++)
      for (int rep = 0; rep < 3; rep++) run_case(w, rep == 1);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule